// File: doc/BRIEF.md
# Staggered Four-Bank Refresh Scheduler

This block decides when memory refresh happens and hands the refresh work to the memory sequencer one bank at a time. A timer counts core clocks up to a programmable interval. The interval is set by a 9-bit field in units of 64 clocks, and a field of zero switches periodic refresh off. When the timer expires, the scheduler runs one refresh sequence. The sequence offers a refresh command for bank 0, then bank 1, bank 2 and bank 3. Each command is held until the sequencer accepts it, and successive commands are separated by a short stagger gap so that the banks do not all draw current in the same cycle.

A separate test input forces one sequence on its rising edge. A request that arrives while a sequence is running is remembered and served as soon as the block is idle again. The interval timer restarts from zero at the start of every sequence, whatever caused that sequence. The stagger code is captured when a sequence starts. It is meant to come from a control register whose reset value is 01, just as the interval field is meant to reset to 0. When the block is built for a single bank, the stagger gap is forced to zero.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `ref_valid_o` and `busy_o` are low until a refresh request arrives.
- R2: With a non-zero interval field N that is held steady, sequences start every 64*N clocks.
- R3: With an interval field of 0, no periodic refresh sequence ever starts.
- R4: A sequence offers exactly four commands on `ref_bank_o`, in the order 0, 1, 2, 3. `busy_o` is high from the first command onward and drops in the cycle after bank 3 is accepted.
- R5: The stagger code sets the idle clocks between one accepted command and the next offer: 00 gives 0, 01 gives 1, 10 gives 2 and 11 gives 4. With code 00, commands are accepted on consecutive clocks when `ref_ready_i` stays high.
- R6: While `ref_valid_o` is high and `ref_ready_i` is low, the command stays valid and `ref_bank_o` does not change.
- R7: A rising edge on `test_req_i` starts a sequence, and the first command appears in the cycle after the clock that sampled the edge. Holding the input high starts no further sequence.
- R8: A request that arrives while a sequence is running is kept. After one idle cycle following the last accept, the next sequence offers bank 0.
- R9: The interval timer restarts at every sequence start, so the next periodic sequence begins 64*N clocks after the latest start, including a start caused by a test request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_i | input | 9 | Refresh interval in units of 64 clocks; 0 disables periodic refresh |
| stagger_i | input | 2 | Stagger code: 00=0, 01=1, 10=2, 11=4 clocks between banks |
| test_req_i | input | 1 | Forces one refresh sequence on its rising edge |
| ref_ready_i | input | 1 | Sequencer accepts the offered command |
| ref_valid_o | output | 1 | Refresh command offered |
| ref_bank_o | output | 2 | Bank targeted by the offered command |
| busy_o | output | 1 | A refresh sequence is in progress |

## Verification
The bench measures the exact spacing between sequence starts for two interval values. A timer with an off-by-one compare would show up as 64*N±1 clocks, and a timer that fails to restart on a test-triggered sequence would fire too early. It stalls the handshake while a second test edge arrives. A design that drops requests seen during a busy sequence would then stay idle, and one that advanced the bank without an accept would skip a bank. It records the clock of every accepted command for all four stagger codes, so a wrong decode, for example treating code 11 as 3, appears as a wrong gap. Finally, it holds the test input high for a long time to catch a level-sensitive trigger that refreshes over and over.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  localparam int STG_W = 2;
  localparam int GAP_W = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_GAP   = 2'd2
  } seq_state_e;

  // Encoded stagger: 00->0, 01->1, 10->2, 11->4 clocks
  function automatic logic [GAP_W-1:0] stagger_gap(input logic [STG_W-1:0] code);
    logic [GAP_W-1:0] g;
    case (code)
      2'b00:   g = 3'd0;
      2'b01:   g = 3'd1;
      2'b10:   g = 3'd2;
      default: g = 3'd4;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/refresh_interval_tmr.sv
module refresh_interval_tmr #(
  parameter int IVL_W    = 9,
  parameter int SCALE_SH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IVL_W-1:0] interval_i,
  input  logic             reload_i,
  output logic             tick_o
);
  localparam int CNT_W = IVL_W + SCALE_SH;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             enabled;
  logic             wrap;

  assign limit   = {interval_i, {SCALE_SH{1'b0}}};
  assign enabled = |interval_i;
  assign wrap    = enabled && (cnt_q >= limit - CNT_W'(1));
  assign tick_o  = wrap;

  always_ff @(posedge clk) begin
    if (rst || !enabled || reload_i || wrap) cnt_q <= '0;
    else                                     cnt_q <= cnt_q + CNT_W'(1);
  end

  p_off_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (interval_i == '0) |=> (cnt_q == '0));

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    (enabled && $stable(interval_i)) |-> (cnt_q < limit));

endmodule

// File: rtl/refresh_req_edge.sv
module refresh_req_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic pulse_o
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_i;
  end

  assign pulse_o = level_i && !level_q;

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/refresh_bank_seq.sv
module refresh_bank_seq
  import refresh_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [GAP_W-1:0]  gap_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              busy_o
);
  localparam logic [BANK_W-1:0] LAST = BANK_W'(NBANK - 1);

  seq_state_e        state_q;
  logic [BANK_W-1:0] bank_q;
  logic [GAP_W-1:0]  gap_q;
  logic [GAP_W-1:0]  gcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      bank_q  <= '0;
      gap_q   <= '0;
      gcnt_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_ISSUE;
            bank_q  <= '0;
            gap_q   <= gap_i;
          end
        end
        SEQ_ISSUE: begin
          if (ready_i) begin
            if (bank_q == LAST) begin
              state_q <= SEQ_IDLE;
              bank_q  <= '0;
            end else begin
              bank_q <= bank_q + BANK_W'(1);
              if (gap_q != '0) begin
                state_q <= SEQ_GAP;
                gcnt_q  <= gap_q - GAP_W'(1);
              end
            end
          end
        end
        SEQ_GAP: begin
          if (gcnt_q == '0) state_q <= SEQ_ISSUE;
          else              gcnt_q  <= gcnt_q - GAP_W'(1);
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign valid_o = (state_q == SEQ_ISSUE);
  assign bank_o  = bank_q;
  assign busy_o  = (state_q != SEQ_IDLE);

  p_hold_offer_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i) |=> (valid_o && $stable(bank_o)));

  p_bank_order_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ready_i && bank_o != LAST) |=> (bank_o == $past(bank_o) + BANK_W'(1)));

  p_last_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ready_i && bank_o == LAST) |=> !busy_o);

  p_zero_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ready_i && bank_o != LAST && gap_q == '0) |=> valid_o);

  p_gap_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_GAP) |-> (gcnt_q < gap_q));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int IVL_W    = 9,
  parameter int SCALE_SH = 6,
  parameter int NBANK    = 4,
  parameter int BANK_W   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IVL_W-1:0]  interval_i,
  input  logic [STG_W-1:0]  stagger_i,
  input  logic              test_req_i,
  input  logic              ref_ready_i,
  output logic              ref_valid_o,
  output logic [BANK_W-1:0] ref_bank_o,
  output logic              busy_o
);
  logic             tick;
  logic             test_edge;
  logic             pend_q;
  logic             start;
  logic             seq_busy;
  logic [GAP_W-1:0] gap_sel;

  generate
    if (NBANK == 1) begin : g_single
      assign gap_sel = '0;
    end else begin : g_multi
      assign gap_sel = stagger_gap(stagger_i);
    end
  endgenerate

  refresh_interval_tmr #(
    .IVL_W   (IVL_W),
    .SCALE_SH(SCALE_SH)
  ) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .interval_i(interval_i),
    .reload_i  (start),
    .tick_o    (tick)
  );

  refresh_req_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .level_i(test_req_i),
    .pulse_o(test_edge)
  );

  assign start = !seq_busy && (pend_q || tick || test_edge);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (pend_q || tick || test_edge) && !start;
  end

  refresh_bank_seq #(
    .NBANK (NBANK),
    .BANK_W(BANK_W)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start_i(start),
    .gap_i  (gap_sel),
    .ready_i(ref_ready_i),
    .valid_o(ref_valid_o),
    .bank_o (ref_bank_o),
    .busy_o (seq_busy)
  );

  assign busy_o = seq_busy;

  p_pend_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && (tick || test_edge)) |=> pend_q);

  p_start_offers_r7: assert property (@(posedge clk) disable iff (rst)
    start |=> (ref_valid_o && ref_bank_o == '0));

endmodule

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [8:0] interval;
  logic [1:0] stagger;
  logic       test_req;
  logic       ready;
  logic       valid;
  logic [1:0] bank;
  logic       busy;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refresh_sched u_dut (
    .clk        (clk),
    .rst        (rst),
    .interval_i (interval),
    .stagger_i  (stagger),
    .test_req_i (test_req),
    .ref_ready_i(ready),
    .ref_valid_o(valid),
    .ref_bank_o (bank),
    .busy_o     (busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_test();
    test_req = 1'b0;
    @(negedge clk);
    test_req = 1'b1;
  endtask

  task automatic wait_start(output int c, input int lim);
    logic pb;
    c  = -1;
    pb = busy;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (busy && !pb) begin
        c = cyc;
        return;
      end
      pb = busy;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!valid, "R1 valid after reset", valid, 0);
    chk(!busy, "R1 busy after reset", busy, 0);
  endtask

  task automatic t_test_hold();
    int hits;
    interval = 0;
    stagger  = 2'b00;
    ready    = 1'b1;
    pulse_test();
    @(negedge clk);
    chk(valid && bank == 0 && busy, "R7 first offer after edge", {valid, bank}, 4);
    for (int b = 1; b < 4; b++) begin
      @(negedge clk);
      chk(valid && bank == b, "R4 bank order R5 no gap", {valid, bank}, 4 + b);
    end
    @(negedge clk);
    chk(!busy && !valid, "R4 sequence ends after bank 3", busy, 0);
    hits = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (busy) hits++;
    end
    chk(hits == 0, "R7 held test input retriggers", hits, 0);
    test_req = 1'b0;
  endtask

  task automatic t_stagger(input logic [1:0] code, input int gap);
    int acc[4];
    int n;
    interval = 0;
    stagger  = code;
    ready    = 1'b1;
    pulse_test();
    n = 0;
    for (int k = 0; k < 60 && n < 4; k++) begin
      @(negedge clk);
      if (valid && ready) begin
        chk(bank == n, "R4 bank order under stagger", bank, n);
        acc[n] = cyc;
        n++;
      end
    end
    chk(n == 4, "R4 four commands", n, 4);
    for (int i = 1; i < 4 && i < n; i++)
      chk(acc[i] - acc[i-1] == gap + 1, "R5 stagger spacing", acc[i] - acc[i-1], gap + 1);
    test_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_pending();
    interval = 0;
    stagger  = 2'b00;
    ready    = 1'b0;
    pulse_test();
    @(negedge clk);
    chk(valid && bank == 0, "R6 offer present", {valid, bank}, 4);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(valid && bank == 0, "R6 offer held while stalled", {valid, bank}, 4);
    end
    test_req = 1'b0;
    @(negedge clk);
    test_req = 1'b1;
    @(negedge clk);
    test_req = 1'b0;
    chk(valid && bank == 0, "R6 offer held across new request", {valid, bank}, 4);
    ready = 1'b1;
    for (int b = 1; b < 4; b++) begin
      @(negedge clk);
      chk(valid && bank == b, "R4 bank order after stall", {valid, bank}, 4 + b);
    end
    @(negedge clk);
    chk(!valid && !busy, "R8 idle cycle between sequences", {valid, busy}, 0);
    @(negedge clk);
    chk(valid && bank == 0, "R8 pending sequence starts", {valid, bank}, 4);
    repeat (5) @(negedge clk);
    chk(!busy, "R8 only one pending sequence", busy, 0);
  endtask

  task automatic t_interval(input int n);
    int c1, c2;
    stagger  = 2'b00;
    ready    = 1'b1;
    interval = 9'(n);
    wait_start(c1, 64 * n * 2 + 80);
    wait_start(c2, 64 * n + 80);
    chk(c1 >= 0 && c2 >= 0, "R2 periodic sequence seen", c2, 1);
    chk(c2 - c1 == 64 * n, "R2 interval period", c2 - c1, 64 * n);
  endtask

  task automatic t_reload();
    int c1, c2, c3;
    stagger  = 2'b00;
    ready    = 1'b1;
    interval = 9'd2;
    wait_start(c1, 400);
    repeat (40) @(negedge clk);
    pulse_test();
    wait_start(c2, 10);
    wait_start(c3, 300);
    chk(c2 >= 0 && c3 >= 0, "R9 starts seen", c3, 1);
    chk(c3 - c2 == 128, "R9 reload on test start", c3 - c2, 128);
    test_req = 1'b0;
  endtask

  task automatic t_off();
    int hits;
    interval = 0;
    test_req = 1'b0;
    repeat (20) @(negedge clk);
    hits = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (busy || valid) hits++;
    end
    chk(hits == 0, "R3 refresh with interval zero", hits, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst      = 1'b1;
    interval = 0;
    stagger  = 2'b01;
    test_req = 1'b0;
    ready    = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_test_hold();
    t_stagger(2'b00, 0);
    t_stagger(2'b01, 1);
    t_stagger(2'b10, 2);
    t_stagger(2'b11, 4);
    t_pending();
    t_interval(1);
    t_interval(3);
    t_reload();
    t_off();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule